// File: doc/BRIEF.md
# SPI Master Shift Engine with Inter-Word Select Pulse

This block is the shift engine of an SPI master. It sends one word of 2 to 16 bits per transmit handshake, MSB first, and gathers the bits returned on MISO into a right-justified receive word. The serial clock comes from the system clock. A divisor is chosen from a three-bit rate field, a range bit and a double-rate flag. In the upper range the divisor saturates at 16384.

The active-low select output has three behaviours. It can idle low, or idle high when automatic selection is on. It can also be forced high for three half serial-clock periods after every word, which lengthens each word period by 1.5 serial-clock periods. A separate override feeds the internal select input from the master-mode bit instead of the select pin. The chosen level is visible on an output.

Configuration is written as one word. A write made during a transfer or a select pulse is held back until the engine is idle again.

Top module: `spi_pw_master`

## Requirements
- R1: Configuration word fields are: [3:0] size code, [6:4] rate, [7] upper range, [8] double rate, [9] CPOL, [10] CPHA, [11] inter-word pulse enable, [12] auto-select, [13] master mode, [14] select override. A write made while idle takes effect on the next cycle. The word length is the size code plus one, so code 1 gives 2 bits and code 9 gives 10 bits.
- R2: With upper range clear, the divisor (system clocks per SCLK period) is 2 shifted left by (rate + double rate), which covers 2..256 or 4..512.
- R3: With upper range set, the divisor is 512 shifted left by (rate + double rate), capped at 16384.
- R4: SCLK rests at CPOL whenever no word is being shifted. Each SCLK level lasts divisor/2 system clocks.
- R5: MOSI carries the word MSB first, and the first bit is present in the cycle after the word is accepted. MISO is sampled at the leading SCLK edge when CPHA=0 and at the trailing edge when CPHA=1.
- R6: The received word is right-justified with the upper bits zero. rx_valid is high for exactly one cycle per word.
- R7: With pulse enable set, ss_n is low while a word shifts. It is then high for exactly 3 × divisor/2 system clocks after each word, for both CPHA values.
- R8: With pulse enable clear, no pulse is produced. ss_n is low during a word, and while idle it equals the auto-select bit.
- R9: ss_int equals the master-mode bit when override is set, and equals the ss_pin input otherwise.
- R10: A configuration write during a word does not change that word's timing. The write takes effect once the engine is idle.
- R11: With size code 0, or with master mode clear, tx_ready stays low and no transfer starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Configuration word |
| tx_valid | input | 1 | Transmit word offered |
| tx_data | input | 16 | Transmit word, right-justified |
| tx_ready | output | 1 | Engine accepts a word this cycle |
| rx_valid | output | 1 | One-cycle pulse, received word present |
| rx_data | output | 16 | Received word, right-justified |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | 1 | Active-low slave select |
| ss_pin | input | 1 | Select level from the pad |
| ss_int | output | 1 | Internal select input after override selection |

## Verification
The assertions assume two things about the inputs. A transmit word is offered only while the engine is idle and configured. Configuration changes reach the live settings only through the write port, so the settings can be treated as frozen for the whole of a word and its trailing pulse. The bench holds to this: it writes configuration only between words, except in the one scenario that deliberately writes mid-word to exercise deferral. It offers a word only through a task that waits for tx_ready, and it keeps MISO either looped back from MOSI or tied to a constant, so the received word is known ahead of time.

// File: rtl/spi_pw_pkg.sv
package spi_pw_pkg;

    localparam int DATA_W    = 16;
    localparam int SIZE_W    = 4;
    localparam int RATE_W    = 3;
    localparam int CNT_W     = 14;
    localparam int NB_W      = $clog2(DATA_W + 1);
    localparam int HCNT_W    = $clog2(2 * DATA_W);
    localparam int LO_BASE   = 2;
    localparam int HI_BASE   = 512;
    localparam int DIV_CAP   = 16384;
    localparam int GAP_HALVES = 3;
    localparam int GCNT_W    = $clog2(GAP_HALVES + 1);

    typedef struct packed {
        logic              ovr;
        logic              master;
        logic              auto_sel;
        logic              pulse_en;
        logic              cpha;
        logic              cpol;
        logic              dbl;
        logic              range_hi;
        logic [RATE_W-1:0] rate;
        logic [SIZE_W-1:0] size;
    } cfg_t;

    localparam int CFG_W = $bits(cfg_t);

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_GAP  = 2'd2
    } st_t;

    // System clocks per full serial-clock period.
    function automatic logic [CNT_W:0] baud_div(cfg_t c);
        int unsigned sh;
        int unsigned v;
        sh = int'(c.rate) + int'(c.dbl);
        if (!c.range_hi) begin
            v = LO_BASE << sh;
        end else begin
            v = HI_BASE << sh;
            if (v > DIV_CAP) v = DIV_CAP;
        end
        return (CNT_W+1)'(v);
    endfunction

    function automatic logic [NB_W-1:0] word_bits(cfg_t c);
        return NB_W'(int'(c.size) + 1);
    endfunction

endpackage

// File: rtl/spi_pw_cfg.sv
module spi_pw_cfg
    import spi_pw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    input  logic              idle,
    input  logic              ss_pin,
    output cfg_t              cur,
    output logic              pend_v,
    output logic              ss_int
);

    cfg_t pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur    <= '0;
            pend   <= '0;
            pend_v <= 1'b0;
        end else if (we) begin
            if (idle) begin
                cur    <= cfg_t'(wdata[CFG_W-1:0]);
                pend_v <= 1'b0;
            end else begin
                pend   <= cfg_t'(wdata[CFG_W-1:0]);
                pend_v <= 1'b1;
            end
        end else if (idle && pend_v) begin
            cur    <= pend;
            pend_v <= 1'b0;
        end
    end

    always_comb begin
        ss_int = cur.ovr ? cur.master : ss_pin;
    end

endmodule

// File: rtl/spi_pw_baud.sv
module spi_pw_baud
    import spi_pw_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic [CW-1:0] half,
    output logic          tick
);

    logic [CW-1:0] cnt;

    always_comb begin
        tick = run && (cnt == half - CW'(1));
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CW'(1);
        end
    end

endmodule

// File: rtl/spi_pw_shift.sv
module spi_pw_shift
    import spi_pw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] ld_data,
    input  logic [NB_W-1:0]   nbits,
    input  logic              shift_out,
    input  logic              sample,
    input  logic              last,
    input  logic              miso,
    output logic              mosi,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid
);

    logic [DATA_W-1:0] txsh;
    logic [DATA_W-1:0] rxsh;
    logic [DATA_W-1:0] rx_next;

    always_comb begin
        rx_next = {rxsh[DATA_W-2:0], miso};
        mosi    = txsh[DATA_W-1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            txsh     <= '0;
            rxsh     <= '0;
            rx_data  <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (load) begin
                txsh <= ld_data << (DATA_W - int'(nbits));
                rxsh <= '0;
            end else begin
                if (shift_out) txsh <= {txsh[DATA_W-2:0], 1'b0};
                if (sample) begin
                    rxsh <= rx_next;
                    if (last) begin
                        rx_data  <= rx_next;
                        rx_valid <= 1'b1;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/spi_pw_master.sv
module spi_pw_master
    import spi_pw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [15:0]       cfg_wdata,
    input  logic              tx_valid,
    input  logic [15:0]       tx_data,
    output logic              tx_ready,
    output logic              rx_valid,
    output logic [15:0]       rx_data,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic              ss_n,
    input  logic              ss_pin,
    output logic              ss_int
);

    st_t               st;
    logic [HCNT_W-1:0] hcnt;
    logic [GCNT_W-1:0] gcnt;
    cfg_t              cur;
    logic              pend_v;
    logic              st_idle;
    logic              st_gap;
    logic              tick;
    logic              accept;
    logic [CNT_W:0]    div;
    logic [CNT_W-1:0]  half;
    logic [NB_W-1:0]   nbits;
    logic [HCNT_W-1:0] last_h;
    logic              smp;
    logic              smp_last;
    logic              shf;
    logic              mosi_sh;

    always_comb begin
        st_idle  = (st == ST_IDLE);
        st_gap   = (st == ST_GAP);
        div      = baud_div(cur);
        half     = div[CNT_W:1];
        nbits    = word_bits(cur);
        last_h   = HCNT_W'({nbits, 1'b0} - 1);
        tx_ready = st_idle && !pend_v && cur.master && (cur.size != '0);
        accept   = tx_valid && tx_ready;
        smp      = tick && (st == ST_XFER) && !hcnt[0];
        smp_last = smp && (hcnt == last_h - HCNT_W'(1));
        shf      = tick && (st == ST_XFER) && hcnt[0] && (hcnt != last_h);
    end

    spi_pw_cfg u_cfg (
        .clk    (clk),
        .rst    (rst),
        .we     (cfg_we),
        .wdata  (cfg_wdata),
        .idle   (st_idle),
        .ss_pin (ss_pin),
        .cur    (cur),
        .pend_v (pend_v),
        .ss_int (ss_int)
    );

    spi_pw_baud #(.CW(CNT_W)) u_baud (
        .clk  (clk),
        .rst  (rst),
        .run  (!st_idle),
        .half (half),
        .tick (tick)
    );

    spi_pw_shift u_shift (
        .clk       (clk),
        .rst       (rst),
        .load      (accept),
        .ld_data   (tx_data),
        .nbits     (nbits),
        .shift_out (shf),
        .sample    (smp),
        .last      (smp_last),
        .miso      (miso),
        .mosi      (mosi_sh),
        .rx_data   (rx_data),
        .rx_valid  (rx_valid)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_IDLE;
            hcnt <= '0;
            gcnt <= '0;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    if (accept) begin
                        st   <= ST_XFER;
                        hcnt <= '0;
                    end
                end
                ST_XFER: begin
                    if (tick) begin
                        if (hcnt == last_h) begin
                            st   <= cur.pulse_en ? ST_GAP : ST_IDLE;
                            gcnt <= '0;
                        end else begin
                            hcnt <= hcnt + HCNT_W'(1);
                        end
                    end
                end
                ST_GAP: begin
                    if (tick) begin
                        if (gcnt == GCNT_W'(GAP_HALVES - 1)) st <= ST_IDLE;
                        else gcnt <= gcnt + GCNT_W'(1);
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        unique case (st)
            ST_XFER: begin
                sclk = cur.cpol ^ cur.cpha ^ hcnt[0];
                mosi = mosi_sh;
                ss_n = 1'b0;
            end
            ST_GAP: begin
                sclk = cur.cpol;
                mosi = 1'b0;
                ss_n = 1'b1;
            end
            default: begin
                sclk = cur.cpol;
                mosi = 1'b0;
                ss_n = cur.auto_sel;
            end
        endcase
    end

endmodule

// File: rtl/spi_pw_chk.sv
module spi_pw_chk
    import spi_pw_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             tx_ready,
    input logic             rx_valid,
    input logic             ss_n,
    input logic             sclk,
    input logic             in_idle,
    input logic             in_gap,
    input logic [CFG_W-1:0] cur_cfg
);

    // R11
    size_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (cur_cfg[SIZE_W-1:0] == '0) |-> !tx_ready);

    // R6
    rx_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    // R7
    gap_high_chk: assert property (@(posedge clk) disable iff (rst)
        in_gap |-> ss_n);

    // R10
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_idle |=> $stable(cur_cfg));

    // R4
    sclk_rest_chk: assert property (@(posedge clk) disable iff (rst)
        in_idle |-> (sclk == cur_cfg[9]));

    // R1
    ready_idle_chk: assert property (@(posedge clk) disable iff (rst)
        tx_ready |-> in_idle);

endmodule

bind spi_pw_master spi_pw_chk i_chk (
    .clk      (clk),
    .rst      (rst),
    .tx_ready (tx_ready),
    .rx_valid (rx_valid),
    .ss_n     (ss_n),
    .sclk     (sclk),
    .in_idle  (st_idle),
    .in_gap   (st_gap),
    .cur_cfg  (cur)
);

// File: tb/test_spi_pw_master.sv
module test_spi_pw_master;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we;
    logic [15:0] cfg_wdata;
    logic        tx_valid;
    logic [15:0] tx_data;
    logic        tx_ready;
    logic        rx_valid;
    logic [15:0] rx_data;
    logic        sclk;
    logic        mosi;
    logic        miso;
    logic        ss_n;
    logic        ss_pin;
    logic        ss_int;
    logic        miso_frc;
    logic        miso_lvl;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    assign miso = miso_frc ? miso_lvl : mosi;

    spi_pw_master i_spi_pw_master (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .tx_valid  (tx_valid),
        .tx_data   (tx_data),
        .tx_ready  (tx_ready),
        .rx_valid  (rx_valid),
        .rx_data   (rx_data),
        .sclk      (sclk),
        .mosi      (mosi),
        .miso      (miso),
        .ss_n      (ss_n),
        .ss_pin    (ss_pin),
        .ss_int    (ss_int)
    );

    function automatic logic [15:0] mk(int size, int rate, bit hi, bit dbl, bit cpol,
                                      bit cpha, bit pen, bit aut, bit mst, bit ovr);
        return {1'b0, ovr, mst, aut, pen, cpha, cpol, dbl, hi, 3'(rate), 4'(size)};
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [15:0] w);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = w;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic send(input logic [15:0] d);
        @(negedge clk);
        tx_valid = 1'b1;
        tx_data  = d;
        while (!tx_ready) @(negedge clk);
        @(negedge clk);
        tx_valid = 1'b0;
    endtask

    task automatic wait_ready();
        while (!tx_ready) @(negedge clk);
    endtask

    task automatic wait_rx(output logic [15:0] d);
        while (!rx_valid) @(negedge clk);
        d = rx_data;
    endtask

    task automatic measure_half(input logic [15:0] w, input int exp, input string req);
        int cnt;
        write_cfg(w);
        send(16'h0002);
        while (sclk == w[9]) @(negedge clk);
        cnt = 0;
        while (sclk != w[9]) begin
            cnt++;
            @(negedge clk);
        end
        chk(cnt == exp, req, cnt, exp);
        wait_ready();
    endtask

    task automatic t_reset();
        chk(tx_ready == 1'b0, "R11 reset ready", tx_ready, 0);
        chk(ss_n == 1'b0, "R8 reset ss_n", ss_n, 0);
        chk(sclk == 1'b0, "R4 reset sclk", sclk, 0);
        chk(rx_valid == 1'b0, "R6 reset rx_valid", rx_valid, 0);
    endtask

    task automatic t_divisors();
        measure_half(mk(1, 0, 0, 0, 0, 0, 0, 0, 1, 0), 1, "R2 lo rate0");
        measure_half(mk(1, 3, 0, 1, 0, 0, 0, 0, 1, 0), 16, "R2 lo rate3 dbl");
        measure_half(mk(1, 0, 1, 0, 0, 0, 0, 0, 1, 0), 256, "R3 hi rate0");
        measure_half(mk(1, 4, 1, 0, 0, 0, 0, 0, 1, 0), 4096, "R3 hi rate4");
        measure_half(mk(1, 7, 1, 0, 0, 0, 0, 0, 1, 0), 8192, "R3 hi rate7 saturate");
        measure_half(mk(1, 3, 1, 1, 0, 0, 0, 0, 1, 0), 4096, "R3 hi rate3 dbl");
    endtask

    task automatic t_loopback();
        logic [15:0] r;
        miso_frc = 1'b0;
        write_cfg(mk(7, 0, 0, 0, 0, 0, 0, 0, 1, 0));
        send(16'h00A5);
        chk(mosi == 1'b1, "R5 msb first cpha0", mosi, 1);
        wait_rx(r);
        chk(r == 16'h00A5, "R5 loopback cpha0", r, 16'h00A5);
        @(negedge clk);
        chk(rx_valid == 1'b0, "R6 rx pulse one cycle", rx_valid, 0);
        wait_ready();
        write_cfg(mk(9, 1, 0, 0, 1, 1, 0, 0, 1, 0));
        chk(sclk == 1'b1, "R4 idle at cpol1", sclk, 1);
        send(16'h02C3);
        chk(mosi == 1'b1, "R5 msb first cpha1", mosi, 1);
        wait_rx(r);
        chk(r == 16'h02C3, "R5 loopback cpha1 cpol1", r, 16'h02C3);
        wait_ready();
    endtask

    task automatic t_sizes();
        logic [15:0] r;
        miso_frc = 1'b1;
        miso_lvl = 1'b1;
        write_cfg(mk(1, 0, 0, 0, 0, 0, 0, 0, 1, 0));
        send(16'h0000);
        wait_rx(r);
        chk(r == 16'h0003, "R1 size code1 two bits", r, 3);
        wait_ready();
        write_cfg(mk(4, 0, 0, 0, 0, 1, 0, 0, 1, 0));
        send(16'h0000);
        wait_rx(r);
        chk(r == 16'h001F, "R6 right justified five bits", r, 31);
        wait_ready();
        write_cfg(mk(9, 0, 0, 0, 0, 0, 0, 0, 1, 0));
        send(16'h0000);
        wait_rx(r);
        chk(r == 16'h03FF, "R1 size code9 ten bits", r, 1023);
        wait_ready();
        miso_frc = 1'b0;
    endtask

    task automatic gap_len(input logic [15:0] w, input int exp, input string req);
        int cnt;
        write_cfg(w);
        send(16'h0005);
        while (ss_n !== 1'b1) @(negedge clk);
        cnt = 0;
        while (ss_n == 1'b1) begin
            cnt++;
            @(negedge clk);
        end
        chk(cnt == exp, req, cnt, exp);
        wait_ready();
    endtask

    task automatic t_gap();
        gap_len(mk(3, 0, 0, 0, 0, 0, 1, 0, 1, 0), 3, "R7 gap half1 cpha0");
        gap_len(mk(3, 1, 0, 0, 0, 1, 1, 0, 1, 0), 6, "R7 gap half2 cpha1");
        gap_len(mk(3, 1, 0, 0, 0, 0, 1, 0, 1, 0), 6, "R7 gap half2 cpha0");
    endtask

    task automatic t_auto();
        write_cfg(mk(3, 0, 0, 0, 0, 0, 0, 1, 1, 0));
        chk(ss_n == 1'b1, "R8 auto idle high", ss_n, 1);
        send(16'h0009);
        chk(ss_n == 1'b0, "R8 low during word", ss_n, 0);
        wait_ready();
        chk(ss_n == 1'b1, "R8 auto high after word", ss_n, 1);
        write_cfg(mk(3, 0, 0, 0, 0, 0, 0, 0, 1, 0));
        chk(ss_n == 1'b0, "R8 no auto idle low", ss_n, 0);
        send(16'h0009);
        wait_ready();
        chk(ss_n == 1'b0, "R8 no pulse after word", ss_n, 0);
    endtask

    task automatic t_override();
        ss_pin = 1'b0;
        write_cfg(mk(3, 0, 0, 0, 0, 0, 0, 0, 1, 1));
        chk(ss_int == 1'b1, "R9 ovr master1", ss_int, 1);
        write_cfg(mk(3, 0, 0, 0, 0, 0, 0, 0, 0, 1));
        ss_pin = 1'b1;
        @(negedge clk);
        chk(ss_int == 1'b0, "R9 ovr master0", ss_int, 0);
        chk(tx_ready == 1'b0, "R11 master clear no ready", tx_ready, 0);
        write_cfg(mk(3, 0, 0, 0, 0, 0, 0, 0, 1, 0));
        chk(ss_int == 1'b1, "R9 pin high", ss_int, 1);
        ss_pin = 1'b0;
        @(negedge clk);
        chk(ss_int == 1'b0, "R9 pin low", ss_int, 0);
    endtask

    task automatic t_defer();
        write_cfg(mk(1, 7, 0, 0, 0, 0, 0, 0, 1, 0));
        send(16'h0001);
        repeat (90) @(negedge clk);
        write_cfg(mk(1, 7, 0, 0, 1, 0, 0, 0, 1, 0));
        chk(sclk == 1'b0, "R10 sclk unchanged mid word", sclk, 0);
        chk(ss_n == 1'b0, "R10 word continues", ss_n, 0);
        wait_ready();
        chk(sclk == 1'b1, "R10 new cpol after word", sclk, 1);
    endtask

    task automatic t_zero_size();
        int seen;
        write_cfg(mk(0, 0, 0, 0, 0, 0, 0, 0, 1, 0));
        @(negedge clk);
        tx_valid = 1'b1;
        tx_data  = 16'h0003;
        seen = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (tx_ready || ss_n || sclk) seen++;
        end
        tx_valid = 1'b0;
        chk(seen == 0, "R11 size0 no transfer", seen, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        n_tests++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1;
        cfg_we = 1'b0;
        cfg_wdata = '0;
        tx_valid = 1'b0;
        tx_data = '0;
        ss_pin = 1'b0;
        miso_frc = 1'b0;
        miso_lvl = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_zero_size();
        t_override();
        t_loopback();
        t_sizes();
        t_gap();
        t_auto();
        t_defer();
        t_divisors();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule